// File: doc/BRIEF.md
# Circular Return Address Stack

This block predicts the target of subroutine returns in an instruction fetch front end by keeping a small hardware copy of the call stack. When the front end sees a call, it presents the call's own address and the block records the address of the next sequential instruction (call address plus the instruction size). When the front end sees a return, the block offers the most recent recorded address as the predicted target and discards that entry.

Storage is a fixed-depth ring with a top pointer and an occupancy counter. When the ring is full, a further call does not stall or get dropped. The pointer wraps and the oldest entry is overwritten. Deep recursion therefore costs mispredictions only on the returns that go further down than the surviving entries. A flush input empties the stack in one cycle. The prediction is combinational from the current top entry. The front end samples it in the same cycle that it asserts the return strobe.

Top module: `ret_addr_stack`

## Requirements
- R1: After reset the stack is empty and `pred_valid` is low.
- R2: A cycle with `call_en` high and `ret_en` low records `call_pc + 4` as the new top. From the next cycle `pred_addr` shows that value and `pred_valid` is high.
- R3: `pred_addr` always shows the current top entry. A cycle with `ret_en` high and `call_en` low on a non-empty stack removes that entry, so the entry below it is shown from the next cycle.
- R4: `pred_valid` is high exactly when the occupancy is non-zero.
- R5: The occupancy saturates at the depth of 8. A call made while the stack is full overwrites the oldest entry. After more than 8 consecutive calls, returns yield only the 8 most recent addresses, newest first, and then `pred_valid` falls.
- R6: A return on an empty stack changes nothing. `pred_valid` stays low, and a later call and return behave as on a fresh stack.
- R7: When `call_en` and `ret_en` are both high, the top entry is replaced by `call_pc + 4` and the depth does not change. On an empty stack this leaves one entry.
- R8: `flush` empties the stack in one cycle and takes priority over `call_en` and `ret_en` in the same cycle.
- R9: The return address is computed modulo 2^32, so a call at `32'hFFFF_FFFC` records `32'h0000_0000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the stack |
| call_en | input | 1 | A call is being fetched |
| call_pc | input | 32 | Address of the call instruction |
| ret_en | input | 1 | A return is being fetched; pop the top |
| pred_addr | output | 32 | Predicted return target (top entry) |
| pred_valid | output | 1 | Stack holds at least one entry |

## Verification
A call and a return can arrive in the same cycle, and the block must then replace the top entry without moving the pointer. The bench provokes this on an empty stack, on a partly filled stack and on a full stack, and also overlays flush on both strobes. Each result is judged against a behavioural queue model. In that model a combined cycle swaps the last element, or appends one if the queue is empty. The model's prediction is compared with `pred_addr` and `pred_valid` on every clock, including after long random mixes of the strobes.

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int ISZ   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          call_en,
  input  logic [AW-1:0] call_pc,
  input  logic          ret_en,
  output logic [AW-1:0] pred_addr,
  output logic          pred_valid
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [AW-1:0] ring [DEPTH];
  logic [PW-1:0] top, top_up, top_dn;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ret_addr;

  assign ret_addr   = call_pc + AW'(ISZ);
  assign top_up     = (top == LAST) ? '0 : top + 1'b1;
  assign top_dn     = (top == '0) ? LAST : top - 1'b1;
  assign pred_addr  = ring[top];
  assign pred_valid = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      top <= '0;
      cnt <= '0;
    end else if (call_en && ret_en) begin
      if (cnt == '0) cnt <= CW'(1);
    end else if (call_en) begin
      top <= top_up;
      if (cnt != FULL) cnt <= cnt + 1'b1;
    end else if (ret_en && cnt != '0) begin
      top <= top_dn;
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !flush && call_en)
      ring[ret_en ? top : top_up] <= ret_addr;
  end

  a_r5_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL);

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !pred_valid);

  a_r2_push_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (call_en && !flush) |=> (pred_valid && pred_addr == $past(call_pc) + AW'(ISZ)));

  a_r6_empty_pop_inert: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !call_en && !flush && cnt == '0) |=> ($stable(top) && cnt == '0));

  a_r7_combo_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && call_en && !flush) |=> $stable(top));

  a_r3_pop_last_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_en && !call_en && !flush && cnt == CW'(1)) |=> !pred_valid);

endmodule

// File: tb/sim_ret_addr_stack.sv
module sim_ret_addr_stack;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        flush = 1'b0, call_en = 1'b0, ret_en = 1'b0;
  logic [31:0] call_pc = '0;
  logic [31:0] pred_addr;
  logic        pred_valid;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  logic [31:0] model[$];

  always #10 clk = ~clk;

  ret_addr_stack u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .call_en(call_en),
    .call_pc(call_pc), .ret_en(ret_en), .pred_addr(pred_addr),
    .pred_valid(pred_valid)
  );

  task automatic compare();
    logic       ev;
    logic [31:0] ea;
    ev = (model.size() != 0);
    ea = ev ? model[$] : 32'h0;
    compared++;
    if (pred_valid !== ev || (ev && pred_addr !== ea)) begin
      mismatched++;
      $display("FAIL %s: valid=%0b addr=%h expected valid=%0b addr=%h",
               tag, pred_valid, pred_addr, ev, ea);
    end
  endtask

  task automatic step(input logic c, input logic [31:0] pc, input logic r, input logic f);
    call_en = c; call_pc = pc; ret_en = r; flush = f;
    if (f) model.delete();
    else if (c && r) begin
      if (model.size() != 0) void'(model.pop_back());
      model.push_back(pc + 32'd4);
    end else if (c) begin
      model.push_back(pc + 32'd4);
      if (model.size() > 8) void'(model.pop_front());
    end else if (r && model.size() != 0) void'(model.pop_back());
    @(negedge clk);
    compare();
    call_en = 0; ret_en = 0; flush = 0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1"; compare();
    tag = "R6"; step(0, 0, 1, 0); step(0, 0, 1, 0);
    tag = "R2"; step(1, 32'h0000_1000, 0, 0); step(1, 32'h0000_2000, 0, 0);
    tag = "R3"; step(0, 0, 1, 0); step(0, 0, 1, 0);
    tag = "R4"; step(0, 0, 1, 0); step(0, 0, 0, 0);
    tag = "R7"; step(1, 32'h0000_3000, 1, 0);
    step(1, 32'h0000_4000, 0, 0); step(1, 32'h0000_5000, 1, 0);
    step(0, 0, 1, 0); step(0, 0, 1, 0);
    tag = "R5";
    for (int i = 0; i < 11; i++) step(1, 32'h0001_0000 + 32'(i * 16), 0, 0);
    tag = "R7"; step(1, 32'h0002_0000, 1, 0);
    tag = "R5";
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0);
    tag = "R6"; step(1, 32'h0000_6000, 0, 0); step(0, 0, 1, 0);
    tag = "R8";
    step(1, 32'h0000_7000, 0, 0); step(1, 32'h0000_8000, 0, 0);
    step(1, 32'h0000_9000, 1, 1); step(0, 0, 0, 0);
    step(1, 32'h0000_A000, 0, 0); step(0, 0, 1, 1);
    tag = "R9"; step(1, 32'hFFFF_FFFC, 0, 0); step(0, 0, 1, 0);
    tag = "R3";
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      step(r[0] | r[1], {$urandom} & 32'hFFFF_FFFC, r[2] | r[3], (r[7:4] == 4'h0));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule